// File: doc/BRIEF.md
# PCM Codec Time-Slot Assignment Controller

This block is the serial control and slot timing logic of a telephony PCM codec. Software-free configuration arrives as an 8-bit control word, clocked in bit by bit on a control clock that rests low, with one data bit taken on each falling edge. The two leading bits select the action: they load a 6-bit slot number into the encoder slot register, the decoder slot register or both, or they power the codec down.

A complete word is held back and applied only at the second frame sync after the word began, so that the change lines up with a frame boundary. Internally, a slot counter restarts at each frame sync and steps once every eight bit-clock rises. While powered, the block raises the transmit enable for the whole slot that matches the encoder slot register and the receive enable for the slot that matches the decoder slot register. When a slot assignment brings the codec out of power-down, both enables remain low for one full settling frame. Every input is sampled through synchronizers and edge detectors on the system clock.

Top module: `pcm_tsa_ctrl`

## Requirements
- R1: After reset the codec is powered down, both enables are low and both slot registers hold 0.
- R2: Each falling edge of the control clock takes one bit from the control data pin, B1 first and B8 last. B3..B8 form the slot number, with B3 as the most significant bit, so slots 0..63 are possible.
- R3: B1=0 loads the encoder slot register and B2=0 loads the decoder slot register. When both are 0, both registers receive the same slot.
- R4: B1=1 together with B2=1 powers the codec down: powered_up falls, both enables stay low and neither slot register changes.
- R5: A complete word takes effect at the second frame sync after its first control-clock pulse. Its first frame sync changes nothing that can be seen.
- R6: A slot assignment that takes effect sets powered_up.
- R7: During the frame that begins with the frame sync that powered the codec up, tx_en and rx_en stay low. From the next frame on, they follow the slot match.
- R8: A slot register that a command does not select keeps its previous slot.
- R9: If the count of control-clock pulses before the next frame sync is not eight, the word is discarded and nothing changes.
- R10: The slot number equals the count of bit-clock rises since the last frame sync, divided by eight and rounded down. While powered, an enable is high for all eight bit periods of its matching slot and low in every other slot.
- R11: slot_active is high exactly when tx_en or rx_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_clk | input | 1 | Control clock, idles low, asynchronous |
| ctl_data | input | 1 | Control data bit, taken on control-clock fall |
| fsync | input | 1 | Frame sync, rising edge starts a frame |
| bit_clk | input | 1 | PCM bit clock, rising edge advances the bit count |
| tx_en | output | 1 | Transmit enable during the encoder slot |
| rx_en | output | 1 | Receive enable during the decoder slot |
| powered_up | output | 1 | Codec is powered |
| slot_active | output | 1 | Either enable is high in the current slot |

## Verification
The case that is hardest to reach from the ports is a settling frame that opens while a slot match is already waiting. The stimulus sets this up by powering the codec up with the decoder only, so the encoder slot keeps its reset value of 0. It then walks through the very frame in which power-up takes effect and checks that both enables stay low there, and that they appear in the following frame. The commands are spread over frames so that the bench can look at the frame between a word's two frame syncs and confirm that the old slots still hold. Words of five and nine pulses are used to confirm that an incomplete or overlong word leaves every slot unchanged.

// File: rtl/pcm_tsa_pkg.sv
// Package: shared constants and types for the time-slot assignment controller.
// Assumes an 8-bit control word whose last six bits carry the slot number.
package pcm_tsa_pkg;
    localparam int CMD_BITS  = 8;
    localparam int SLOT_BITS = 6;
    localparam int SCNT_BITS = 8;
    localparam int BPS       = 8;   // bit clocks per slot

    // Control shifter phases
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_WAIT  = 2'd2
    } sh_state_t;

    // Decoded control word, B1 in the top bit
    typedef struct packed {
        logic                 enc_n;
        logic                 dec_n;
        logic [SLOT_BITS-1:0] slot;
    } ctl_word_t;
endpackage

// File: rtl/tsa_sync_bit.sv
// Module: brings an asynchronous level into the clk domain through a flop chain.
// Assumes STAGES >= 2; output latency equals STAGES cycles.
module tsa_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tsa_edge_det.sv
// Module: synchronizes an asynchronous strobe and emits a one-cycle pulse
// on the chosen edge. FALLING picks the falling edge variant.
// Assumes the input stays in each level for more than STAGES+1 clk cycles.
module tsa_edge_det #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic lvl;
    logic lvl_d;

    tsa_sync_bit #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (lvl)
    );

    // Remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = lvl_d & ~lvl;
        end else begin : g_rise
            assign pulse = lvl & ~lvl_d;
        end
    endgenerate
endmodule

// File: rtl/tsa_ctl_shifter.sv
// Module: collects the serial control word and releases it as a one-cycle
// apply pulse at the second frame sync after the word started.
// Assumes edge pulses are one clk cycle wide; frame sync wins over a
// control edge that arrives in the same cycle.
module tsa_ctl_shifter
    import pcm_tsa_pkg::*;
#(
    parameter int NBITS = CMD_BITS,
    localparam int CNT_W = $clog2(NBITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_fall,
    input  logic             ctl_bit,
    input  logic             fs_rise,
    output logic             cmd_apply,
    output logic [NBITS-1:0] cmd_word,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NBITS);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(NBITS + 1);

    sh_state_t state;

    // Shift, count and frame-align the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SH_IDLE;
            cmd_word  <= '0;
            bit_cnt   <= '0;
            cmd_apply <= 1'b0;
        end else begin
            cmd_apply <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    if (ctl_fall && !fs_rise) begin
                        cmd_word <= {cmd_word[NBITS-2:0], ctl_bit};
                        bit_cnt  <= CNT_W'(1);
                        state    <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (fs_rise) begin
                        bit_cnt <= '0;
                        state   <= (bit_cnt == FULL) ? SH_WAIT : SH_IDLE;
                    end else if (ctl_fall) begin
                        cmd_word <= {cmd_word[NBITS-2:0], ctl_bit};
                        bit_cnt  <= (bit_cnt >= FULL) ? OVER : bit_cnt + 1'b1;
                    end
                end
                SH_WAIT: begin
                    if (fs_rise) begin
                        cmd_apply <= 1'b1;
                        state     <= SH_IDLE;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tsa_slot_timer.sv
// Module: counts bit clocks within a frame and reports the current slot.
// Assumes frame sync restarts the count; the slot number saturates at its top.
module tsa_slot_timer
    import pcm_tsa_pkg::*;
#(
    parameter int BITS_PER_SLOT = BPS,
    parameter int CW            = SCNT_BITS,
    localparam int PW           = $clog2(BITS_PER_SLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_rise,
    input  logic          bclk_rise,
    output logic [CW-1:0] slot_cnt
);
    localparam logic [PW-1:0] LAST = PW'(BITS_PER_SLOT - 1);
    logic [PW-1:0] phase;

    // Advance bit phase and slot number, restart on frame sync
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            slot_cnt <= '0;
        end else if (fs_rise) begin
            phase    <= '0;
            slot_cnt <= '0;
        end else if (bclk_rise) begin
            if (phase == LAST) begin
                phase <= '0;
                if (slot_cnt != '1) slot_cnt <= slot_cnt + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_tsa_ctrl.sv
// Module: top of the codec time-slot assignment controller. Holds slot
// registers and power state, applies decoded commands, and drives the
// transmit and receive enables from the slot counter.
// Assumes all inputs are asynchronous to clk and slower than a few cycles.
module pcm_tsa_ctrl
    import pcm_tsa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_clk,
    input  logic ctl_data,
    input  logic fsync,
    input  logic bit_clk,
    output logic tx_en,
    output logic rx_en,
    output logic powered_up,
    output logic slot_active
);
    localparam int CNT_W = $clog2(CMD_BITS + 2);
    localparam int PAD   = SCNT_BITS - SLOT_BITS;

    logic                 ctl_fall;
    logic                 fs_rise;
    logic                 bclk_rise;
    logic                 data_s;
    logic                 cmd_apply;
    logic [CMD_BITS-1:0]  cmd_raw;
    logic [CNT_W-1:0]     bit_cnt;
    logic [SCNT_BITS-1:0] slot_cnt;
    logic [SLOT_BITS-1:0] enc_slot;
    logic [SLOT_BITS-1:0] dec_slot;
    logic                 settle;
    ctl_word_t            cmd;

    tsa_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_ctl_edge (
        .clk(clk), .rst_n(rst_n), .din(ctl_clk), .pulse(ctl_fall));
    tsa_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_fs_edge (
        .clk(clk), .rst_n(rst_n), .din(fsync), .pulse(fs_rise));
    tsa_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_bclk_edge (
        .clk(clk), .rst_n(rst_n), .din(bit_clk), .pulse(bclk_rise));
    tsa_sync_bit #(.STAGES(SYNC_STAGES)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .din(ctl_data), .dout(data_s));

    tsa_ctl_shifter #(.NBITS(CMD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_fall (ctl_fall),
        .ctl_bit  (data_s),
        .fs_rise  (fs_rise),
        .cmd_apply(cmd_apply),
        .cmd_word (cmd_raw),
        .bit_cnt  (bit_cnt)
    );

    tsa_slot_timer #(.BITS_PER_SLOT(BPS), .CW(SCNT_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_rise  (fs_rise),
        .bclk_rise(bclk_rise),
        .slot_cnt (slot_cnt)
    );

    assign cmd = ctl_word_t'(cmd_raw);

    // Apply commands, track power state and the settling frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_slot   <= '0;
            dec_slot   <= '0;
            powered_up <= 1'b0;
            settle     <= 1'b0;
        end else if (cmd_apply) begin
            if (cmd.enc_n && cmd.dec_n) begin
                powered_up <= 1'b0;
                settle     <= 1'b0;
            end else begin
                if (!cmd.enc_n) enc_slot <= cmd.slot;
                if (!cmd.dec_n) dec_slot <= cmd.slot;
                if (!powered_up) settle <= 1'b1;
                powered_up <= 1'b1;
            end
        end else if (fs_rise) begin
            settle <= 1'b0;
        end
    end

    // Enables follow the slot match once powered and settled
    always_comb begin
        tx_en = powered_up && !settle && (slot_cnt == {{PAD{1'b0}}, enc_slot});
        rx_en = powered_up && !settle && (slot_cnt == {{PAD{1'b0}}, dec_slot});
        slot_active = tx_en | rx_en;
    end
endmodule

// File: rtl/pcm_tsa_checker.sv
// Module: property checker for pcm_tsa_ctrl, attached with bind.
// Assumes the internal strobe and state names of the top module.
module pcm_tsa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       rx_en,
    input logic       powered_up,
    input logic       slot_active,
    input logic       cmd_apply,
    input logic       fs_rise,
    input logic       bclk_rise,
    input logic [3:0] bit_cnt,
    input logic [5:0] enc_slot,
    input logic [5:0] dec_slot
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> !powered_up && enc_slot == 6'd0 && dec_slot == 6'd0);

    a_r4_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !powered_up |-> !tx_en && !rx_en && !slot_active);

    a_r5_power_moves_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(powered_up) |-> $past(cmd_apply));

    a_r7_settle_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_up) |-> !tx_en && !rx_en);

    a_r8_slots_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_apply) |-> $stable(enc_slot) && $stable(dec_slot));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd9);

    a_r10_tx_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_en) |-> $past(bclk_rise) || $past(fs_rise) || $past(cmd_apply));
endmodule

bind pcm_tsa_ctrl pcm_tsa_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .powered_up (powered_up),
    .slot_active(slot_active),
    .cmd_apply  (cmd_apply),
    .fs_rise    (fs_rise),
    .bclk_rise  (bclk_rise),
    .bit_cnt    (bit_cnt),
    .enc_slot   (enc_slot),
    .dec_slot   (dec_slot)
);

// File: tb/test_pcm_tsa_ctrl.sv
// Directed bench for pcm_tsa_ctrl: one task per scenario, each self-checking.
module test_pcm_tsa_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_clk = 1'b0;
    logic ctl_data = 1'b0;
    logic fsync = 1'b0;
    logic bit_clk = 1'b0;
    logic tx_en, rx_en, powered_up, slot_active;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_tsa_ctrl i_pcm_tsa_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_data(ctl_data),
        .fsync(fsync), .bit_clk(bit_clk), .tx_en(tx_en), .rx_en(rx_en),
        .powered_up(powered_up), .slot_active(slot_active));

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic fsync_pulse();
        fsync = 1'b1; wait_n(4);
        fsync = 1'b0; wait_n(4);
    endtask

    task automatic bclk_pulse();
        bit_clk = 1'b1; wait_n(3);
        bit_clk = 1'b0; wait_n(3);
    endtask

    // Shift n bits, bits[n-1] first (B1 first)
    task automatic send_bits(input int n, input logic [8:0] bits);
        for (int i = n - 1; i >= 0; i--) begin
            ctl_data = bits[i]; wait_n(3);
            ctl_clk = 1'b1;     wait_n(3);
            ctl_clk = 1'b0;     wait_n(4);
        end
    endtask

    // Start a frame, step to bit position 8*slot+off, compare outputs
    task automatic frame_check(input string req, input int slot, input int off,
                               input logic etx, input logic erx, input logic epw);
        fsync_pulse();
        repeat (8 * slot + off) bclk_pulse();
        check(req, "tx_en", tx_en, etx);
        check(req, "rx_en", rx_en, erx);
        check(req, "powered_up", powered_up, epw);
        check("R11", "slot_active", slot_active, etx | erx);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wait_n(5);
        rst_n = 1'b1; wait_n(2);
        check("R1", "powered_up", powered_up, 1'b0);
        check("R1", "tx_en", tx_en, 1'b0);
        check("R1", "rx_en", rx_en, 1'b0);
    endtask

    // Decoder-only slot 5: powers up, settle frame, encoder still at slot 0
    task automatic t_power_up_decoder();
        send_bits(8, 9'b0_10_000101);
        frame_check("R5", 5, 3, 1'b0, 1'b0, 1'b0);
        frame_check("R7", 5, 3, 1'b0, 1'b0, 1'b1);
        frame_check("R6", 5, 3, 1'b0, 1'b1, 1'b1);
        frame_check("R1", 0, 0, 1'b1, 1'b0, 1'b1);
        frame_check("R10", 0, 7, 1'b1, 1'b0, 1'b1);
        frame_check("R10", 5, 0, 1'b0, 1'b1, 1'b1);
        frame_check("R10", 5, 7, 1'b0, 1'b1, 1'b1);
        frame_check("R10", 4, 7, 1'b0, 1'b0, 1'b1);
        frame_check("R10", 6, 0, 1'b0, 1'b0, 1'b1);
    endtask

    // Encoder-only slot 9, decoder keeps slot 5
    task automatic t_encoder_only();
        send_bits(8, 9'b0_01_001001);
        frame_check("R5", 9, 2, 1'b0, 1'b0, 1'b1);
        frame_check("R3", 9, 2, 1'b1, 1'b0, 1'b1);
        frame_check("R8", 5, 2, 1'b0, 1'b1, 1'b1);
        frame_check("R8", 0, 2, 1'b0, 1'b0, 1'b1);
    endtask

    // Both registers to slot 42 (101010, B3 is MSB)
    task automatic t_both();
        send_bits(8, 9'b0_00_101010);
        frame_check("R5", 9, 2, 1'b1, 1'b0, 1'b1);
        frame_check("R2", 42, 4, 1'b1, 1'b1, 1'b1);
        frame_check("R3", 9, 2, 1'b0, 1'b0, 1'b1);
    endtask

    // Five-pulse and nine-pulse words are dropped
    task automatic t_bad_count();
        send_bits(5, 9'b0_0000_1000);
        frame_check("R9", 42, 1, 1'b1, 1'b1, 1'b1);
        frame_check("R9", 42, 1, 1'b1, 1'b1, 1'b1);
        send_bits(9, 9'b0_01_000000);
        frame_check("R9", 42, 1, 1'b1, 1'b1, 1'b1);
        frame_check("R9", 0, 1, 1'b0, 1'b0, 1'b1);
    endtask

    // Power-down, then re-power with encoder slot 63
    task automatic t_power_cycle();
        send_bits(8, 9'b0_11_000111);
        frame_check("R5", 42, 1, 1'b1, 1'b1, 1'b1);
        frame_check("R4", 42, 1, 1'b0, 1'b0, 1'b0);
        send_bits(8, 9'b0_01_111111);
        frame_check("R4", 63, 3, 1'b0, 1'b0, 1'b0);
        frame_check("R7", 63, 3, 1'b0, 1'b0, 1'b1);
        frame_check("R6", 63, 3, 1'b1, 1'b0, 1'b1);
        frame_check("R4", 42, 3, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_power_up_decoder();
        t_encoder_only();
        t_both();
        t_bad_count();
        t_power_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule